// File: doc/BRIEF.md
# Two-Step Subranging Converter Correction Decoder

This block is the digital back end of a two-step subranging analog-to-digital converter that uses a coarse voltage estimator. Each sample delivers three thermometer words: six estimator comparators, eight comparators from the first flash pass on the coarse (upper) ladder, and the same eight comparators reused for the second flash pass on the fine (lower) ladder. The estimator picks a window of eight coarse taps out of 32. That window overlaps the estimator's own span by one sixteenth of full scale on each side. The first flash pass therefore corrects any estimator error up to 16 LSBs.

The decoder does four things. It turns the estimator word into a 2-bit code and a window base tap. It corrects the code with the first flash result. It forms the five upper result bits from the window base plus the coarse flash count, and the three lower bits from the fine flash count. All results are registered together with a one-cycle valid strobe. A word that breaks the thermometer rule is flagged for that sample. It is not repaired, and decoding proceeds on the number of ones in the word.

Top module: `msadc_correction_decoder`

## Requirements
- R1: After reset, `result`, `window_base` and `corr_code` are 0, and `result_valid` and `therm_error` are low.
- R2: A thermometer word is well formed when no 1 sits above a 0, with bit 0 as the lowest comparator. Any other pattern is a bubble.
- R3: With n ones in `est_therm`, the estimator code is (n+1)/2 (integer division), capped at 3. For example, 000111 gives code 2.
- R4: `window_base` is code*8-4, clamped to 0..24. Codes 0, 1, 2 and 3 therefore give 0, 4, 12 and 20.
- R5: `result[7:3]` is `window_base` plus the number of ones in `fl1_therm`, saturated at 31.
- R6: `corr_code` is the estimator code minus 1 when `fl1_therm` holds fewer than 4 ones and the code is nonzero. Otherwise `corr_code` is the estimator code unchanged.
- R7: `result[2:0]` is the number of ones in `fl2_therm`, limited to 7.
- R8: A sample presented with `in_valid` high at a clock edge appears on the outputs after that edge. `result_valid` is high for exactly that one cycle.
- R9: While `in_valid` is low, `result`, `window_base` and `corr_code` keep their values.
- R10: `therm_error` is high for one cycle, together with `result_valid`, when any of the three words of that sample is a bubble. Decoding still uses the number of ones in each word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Sample strobe for the three comparator words |
| est_therm | input | 6 | Estimator comparator word, bit 0 lowest |
| fl1_therm | input | 8 | First (coarse) flash comparator word |
| fl2_therm | input | 8 | Second (fine) flash comparator word |
| result | output | 8 | Registered conversion result {5 MSBs, 3 LSBs} |
| result_valid | output | 1 | One-cycle strobe for a new result |
| window_base | output | 5 | Coarse tap where the comparator window starts |
| corr_code | output | 2 | Estimator code after correction |
| therm_error | output | 1 | Bubble seen in the sample just decoded |

## Verification
A wrong estimator mapping or window clamp shows up on `window_base`, and also as an offset of eight taps in `result[7:3]`. Both appear one cycle after the sample. A broken borrow decision shows on `corr_code` on the samples whose coarse count is near four. That is why stimulus is weighted toward coarse counts around the window midpoint and toward the end codes 0 and 3. Bubble handling and hold behaviour are each observed within one cycle: a missed flag, or a result that moves without a strobe, is visible at the next sampling point.

// File: rtl/msadc_pkg.sv
`timescale 1ns/1ps
package msadc_pkg;
    parameter int EST_W   = 6;
    parameter int FL_W    = 8;
    parameter int CODE_W  = 2;
    parameter int MSB_W   = 5;
    parameter int LSB_W   = 3;

    localparam int RES_W     = MSB_W + LSB_W;
    localparam int EST_CNT_W = $clog2(EST_W + 1);
    localparam int FL_CNT_W  = $clog2(FL_W + 1);
    localparam int CODE_MAX  = (1 << CODE_W) - 1;
    localparam int TAPS      = 1 << MSB_W;
    localparam int TAPS_PER_CODE = TAPS >> CODE_W;
    localparam int BASE_MAX  = TAPS - FL_W;
    localparam int MSB_MAX   = TAPS - 1;
    localparam int LSB_MAX   = (1 << LSB_W) - 1;

    typedef struct packed {
        logic [RES_W-1:0]  result;
        logic              valid;
        logic [MSB_W-1:0]  base;
        logic [CODE_W-1:0] corr;
        logic              err;
    } dec_state_t;
endpackage

// File: rtl/msadc_therm_reader.sv
`timescale 1ns/1ps
module msadc_therm_reader #(
    parameter int W = 8,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  word,
    output logic [CW-1:0] ones,
    output logic          bubble
);
    logic [W:0] ext;
    logic [W:0] ext_inc;

    always_comb begin
        ones = '0;
        for (int i = 0; i < W; i++) begin
            ones = ones + CW'(word[i]);
        end
    end

    // well formed words are 0..01..1; adding one then clears every set bit
    assign ext     = {1'b0, word};
    assign ext_inc = ext + (W+1)'(1);
    assign bubble  = |(ext & ext_inc);
endmodule

// File: rtl/msadc_coarse_window.sv
`timescale 1ns/1ps
module msadc_coarse_window
    import msadc_pkg::*;
(
    input  logic [EST_CNT_W-1:0] est_ones,
    output logic [CODE_W-1:0]    code,
    output logic [MSB_W-1:0]     base
);
    int c;
    int b;

    always_comb begin
        c = (int'(est_ones) + 1) / 2;
        if (c > CODE_MAX) c = CODE_MAX;
        b = c * TAPS_PER_CODE - TAPS_PER_CODE / 2;
        if (b < 0) b = 0;
        if (b > BASE_MAX) b = BASE_MAX;
        code = CODE_W'(c);
        base = MSB_W'(b);
    end
endmodule

// File: rtl/msadc_correction_decoder.sv
`timescale 1ns/1ps
module msadc_correction_decoder
    import msadc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [EST_W-1:0]     est_therm,
    input  logic [FL_W-1:0]      fl1_therm,
    input  logic [FL_W-1:0]      fl2_therm,
    output logic [RES_W-1:0]     result,
    output logic                 result_valid,
    output logic [MSB_W-1:0]     window_base,
    output logic [CODE_W-1:0]    corr_code,
    output logic                 therm_error
);
    localparam int NFL = 2;

    logic [EST_CNT_W-1:0] est_ones;
    logic                 est_bub;
    logic [FL_CNT_W-1:0]  fl_ones [NFL];
    logic [NFL-1:0]       fl_bub;
    logic [FL_W-1:0]      fl_word [NFL];
    logic [CODE_W-1:0]    est_code;
    logic [MSB_W-1:0]     est_base;

    dec_state_t state_d, state_q;

    assign fl_word[0] = fl1_therm;
    assign fl_word[1] = fl2_therm;

    msadc_therm_reader #(.W(EST_W)) est_rd_i (
        .word(est_therm), .ones(est_ones), .bubble(est_bub)
    );

    for (genvar g = 0; g < NFL; g++) begin : g_flash
        msadc_therm_reader #(.W(FL_W)) fl_rd_i (
            .word(fl_word[g]), .ones(fl_ones[g]), .bubble(fl_bub[g])
        );
    end

    msadc_coarse_window win_i (
        .est_ones(est_ones), .code(est_code), .base(est_base)
    );

    int msb_sum;
    int lsb_val;

    always_comb begin
        state_d       = state_q;
        state_d.valid = 1'b0;
        state_d.err   = 1'b0;
        msb_sum       = int'(est_base) + int'(fl_ones[0]);
        if (msb_sum > MSB_MAX) msb_sum = MSB_MAX;
        lsb_val       = int'(fl_ones[1]);
        if (lsb_val > LSB_MAX) lsb_val = LSB_MAX;
        if (in_valid) begin
            state_d.valid  = 1'b1;
            state_d.err    = est_bub | (|fl_bub);
            state_d.base   = est_base;
            state_d.result = {MSB_W'(msb_sum), LSB_W'(lsb_val)};
            if ((int'(fl_ones[0]) < FL_W / 2) && (est_code != '0))
                state_d.corr = est_code - CODE_W'(1);
            else
                state_d.corr = est_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign result       = state_q.result;
    assign result_valid = state_q.valid;
    assign window_base  = state_q.base;
    assign corr_code    = state_q.corr;
    assign therm_error  = state_q.err;
endmodule

// File: rtl/msadc_correction_checker.sv
`timescale 1ns/1ps
module msadc_correction_checker
    import msadc_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [RES_W-1:0]     result,
    input logic                 result_valid,
    input logic [MSB_W-1:0]     window_base,
    input logic [CODE_W-1:0]    corr_code,
    input logic                 therm_error
);
    assert_strobe_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> result_valid);

    assert_no_spurious_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !result_valid);

    assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(window_base) && $stable(corr_code)));

    assert_error_with_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        therm_error |-> result_valid);

    assert_msb_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (result[RES_W-1:LSB_W] >= window_base));

    assert_base_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (window_base[1:0] == 2'b00 && int'(window_base) <= BASE_MAX));
endmodule

bind msadc_correction_decoder msadc_correction_checker chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .result(result),
    .result_valid(result_valid), .window_base(window_base),
    .corr_code(corr_code), .therm_error(therm_error)
);

// File: tb/msadc_correction_decoder_tb.sv
`timescale 1ns/1ps
module msadc_correction_decoder_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [5:0] est_therm = '0;
    logic [7:0] fl1_therm = '0;
    logic [7:0] fl2_therm = '0;
    logic [7:0] result;
    logic       result_valid;
    logic [4:0] window_base;
    logic [1:0] corr_code;
    logic       therm_error;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    msadc_correction_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .est_therm(est_therm), .fl1_therm(fl1_therm), .fl2_therm(fl2_therm),
        .result(result), .result_valid(result_valid), .window_base(window_base),
        .corr_code(corr_code), .therm_error(therm_error)
    );

    function automatic int ones8(input logic [7:0] w);
        int n = 0;
        for (int i = 0; i < 8; i++) n += int'(w[i]);
        return n;
    endfunction

    function automatic bit is_bubble(input logic [7:0] w, input int width);
        bit seen_zero = 0;
        for (int i = 0; i < width; i++) begin
            if (!w[i]) seen_zero = 1;
            else if (seen_zero) return 1;
        end
        return 0;
    endfunction

    function automatic logic [7:0] therm(input int n);
        logic [7:0] w = '0;
        for (int i = 0; i < n; i++) w[i] = 1'b1;
        return w;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply(input logic [5:0] e, input logic [7:0] f1, input logic [7:0] f2);
        int n, code, base, msb, lsb, corr;
        bit err;
        @(negedge clk);
        est_therm = e; fl1_therm = f1; fl2_therm = f2; in_valid = 1'b1;
        n = ones8({2'b00, e});
        code = (n + 1) / 2; if (code > 3) code = 3;
        base = code * 8 - 4; if (base < 0) base = 0; if (base > 24) base = 24;
        msb = base + ones8(f1); if (msb > 31) msb = 31;
        lsb = ones8(f2); if (lsb > 7) lsb = 7;
        corr = (ones8(f1) < 4 && code > 0) ? code - 1 : code;
        err = is_bubble({2'b00, e}, 6) | is_bubble(f1, 8) | is_bubble(f2, 8);
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 valid", int'(result_valid), 1);
        check("R3/R4 window_base", int'(window_base), base);
        check("R5 msb", int'(result[7:3]), msb);
        check("R6 corr_code", int'(corr_code), corr);
        check("R7 lsb", int'(result[2:0]), lsb);
        check("R2/R10 therm_error", int'(therm_error), int'(err));
    endtask

    task automatic idle_check;
        logic [7:0] r = result;
        logic [4:0] b = window_base;
        logic [1:0] c = corr_code;
        @(negedge clk);
        est_therm = 6'h2a; fl1_therm = 8'hff; fl2_therm = 8'h0f;
        @(negedge clk);
        check("R8 strobe drop", int'(result_valid), 0);
        check("R10 error drop", int'(therm_error), 0);
        check("R9 hold result", int'(result), int'(r));
        check("R9 hold base", int'(window_base), int'(b));
        check("R9 hold corr", int'(corr_code), int'(c));
    endtask

    initial begin
        #4000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R1 result", int'(result), 0);
        check("R1 valid", int'(result_valid), 0);
        check("R1 base", int'(window_base), 0);
        check("R1 corr", int'(corr_code), 0);
        check("R1 error", int'(therm_error), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // directed corners
        apply(6'b000111, therm(3), therm(5));   // R3 code 2, R6 borrow
        apply(6'b000111, therm(4), therm(8));   // R6 no borrow, R7 limit
        apply(6'b000000, therm(2), therm(0));   // R4 code 0 clamp
        apply(6'b000000, therm(8), therm(7));
        apply(6'b111111, therm(8), therm(8));   // R4 code 3, R5 top
        apply(6'b000001, therm(0), therm(1));   // code 1 borrow to 0
        apply(6'b000101, therm(4), therm(2));   // R2 estimator bubble
        apply(6'b000011, 8'b0001_0110, therm(3)); // R2 flash bubble
        apply(6'b001111, therm(3), 8'b1000_0000); // R10 fine bubble
        idle_check();
        for (int k = 0; k < 300; k++) begin
            logic [5:0] e  = 6'(therm(int'($urandom_range(0, 6))));
            logic [7:0] f1 = therm(int'($urandom_range(0, 8)));
            logic [7:0] f2 = therm(int'($urandom_range(0, 8)));
            if ($urandom_range(0, 9) == 0) f1[$urandom_range(0, 7)] ^= 1'b1;
            if ($urandom_range(0, 9) == 0) e[$urandom_range(0, 5)] ^= 1'b1;
            apply(e, f1, f2);
            if (k % 25 == 0) idle_check();
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule